// File: doc/BRIEF.md
# DAC bus write sequencer

This block sits on the host side of a quad 8-bit converter whose parallel bus has two register levels per channel. Each channel has a staging register, which is filled by a low pulse on an active-low write strobe. A shared active-low load strobe then copies all four staging registers into the registers that set the outputs. The sequencer takes one request at a time: a 2-bit channel number, an 8-bit code, an update flag and a load-only flag. It then plays the bus cycle with every pulse width, setup interval and hold interval counted in system clock cycles.

The pulse widths and intervals are given as nanosecond minimums plus a clock period. Each one is rounded up to whole cycles during elaboration. The block supports three commands: a plain write, a write followed by one global load pulse, and a load pulse on its own. A request is taken when `req_valid` and `ready` are both high at a rising clock edge. `ready` stays low until the command has finished, and `done` marks the end of the command with a single-cycle pulse.

Top module: `dac_wr_seq`

## Requirements
- R1: While reset is held and just after it is released, `dac_wr_n` and `dac_ld_n` are 1, `ready` is 1, `done` is 0, and `dac_addr` and `dac_data` are 0.
- R2: A write to channel c puts c on `dac_addr`, where channels A, B, C and D are coded 00, 01, 10 and 11. The requested code appears on `dac_data` and is present when `dac_wr_n` rises.
- R3: `dac_wr_n` stays low for exactly ceil(WR_LOW_NS / CLK_NS) cycles, which is 6 with the defaults.
- R4: Address and data are driven at least one cycle before `dac_wr_n` falls. They stay constant while it is low and for at least one cycle after it rises, which covers the zero-setup address rule, the data setup time and the data hold time.
- R5: `dac_ld_n` stays low for exactly ceil(LD_LOW_NS / CLK_NS) cycles, which is 6 with the defaults. It is never low in the same cycle as `dac_wr_n`, and it falls only after `dac_wr_n` has been high for at least one cycle.
- R6: A write with `req_update`=1 is followed by exactly one load pulse. A write with `req_update`=0 produces no load pulse.
- R7: `ready` is low from the cycle after acceptance up to and including the `done` cycle. A `req_valid` raised while `ready` is low does not change the bus and produces no strobe.
- R8: `done` is high for exactly one cycle per command, and `ready` returns to 1 in the next cycle.
- R9: A load-only request (`req_load_only`=1) produces no write pulse. It ignores `req_chan`, `req_code` and `req_update`, and leaves `dac_addr` and `dac_data` unchanged.
- R10: Between commands, `dac_addr` and `dac_data` keep the values of the last write, and both strobes stay high.
- R11: With the defaults, `done` rises on the 8th clock edge after the accepting edge for a plain write, on the 15th for a write with update, and on the 7th for a load-only command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted together with `ready` |
| req_load_only | input | 1 | 1: issue only the global load pulse |
| req_update | input | 1 | 1: follow the write with a load pulse |
| req_chan | input | 2 | Channel number, 00 to 11 for channels A to D |
| req_code | input | 8 | Code to write into the staging register |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle end-of-command pulse |
| dac_addr | output | 2 | Channel select to the converter bus |
| dac_data | output | 8 | Data to the converter bus |
| dac_wr_n | output | 1 | Active-low write strobe |
| dac_ld_n | output | 1 | Active-low global load strobe |

## Verification
If the interval timer were off by one, a strobe would be a cycle too short or too long. This shows in the very next pulse as a wrong measured width on `dac_wr_n` or `dac_ld_n`, and as a wrong count of edges before `done`. If the sequencer took a wrong branch after the write hold, the load pulse would go missing or appear without being requested, and `done` would arrive 7 edges off the expected count. If a request were captured while busy, `dac_addr` or `dac_data` would change within one cycle, while a strobe was low or in its hold cycle, and an extra strobe would follow.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_WR_LOW  = 3'd2,
    ST_WR_HOLD = 3'd3,
    ST_LD_LOW  = 3'd4,
    ST_LD_REC  = 3'd5,
    ST_DONE    = 3'd6
  } seq_state_t;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_wr_timer.sv
module dac_wr_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | ~expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // An idle timer must not wrap: interval lengths would explode (R3, R5)
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);

endmodule

// File: rtl/dac_wr_fsm.sv
module dac_wr_fsm
  import dac_wr_pkg::*;
#(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned SU_CYC   = 1,
  parameter int unsigned WR_CYC   = 6,
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned LD_CYC   = 6,
  parameter int unsigned REC_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_load_only,
  input  logic             req_update,
  input  logic             tmr_expired,
  output seq_state_t       state_nxt,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] SU_VAL   = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] WR_VAL   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_VAL   = CNT_W'(LD_CYC - 1);
  localparam logic [CNT_W-1:0] REC_VAL  = CNT_W'(REC_CYC - 1);

  seq_state_t state_q;
  logic       upd_q;

  assign accept = (state_q == ST_IDLE) & req_valid;

  // next-state decode
  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) state_nxt = req_load_only ? ST_LD_LOW : ST_SETUP;
      end
      ST_SETUP:   if (tmr_expired) state_nxt = ST_WR_LOW;
      ST_WR_LOW:  if (tmr_expired) state_nxt = ST_WR_HOLD;
      ST_WR_HOLD: if (tmr_expired) state_nxt = upd_q ? ST_LD_LOW : ST_DONE;
      ST_LD_LOW:  if (tmr_expired) state_nxt = ST_LD_REC;
      ST_LD_REC:  if (tmr_expired) state_nxt = ST_DONE;
      ST_DONE:    state_nxt = ST_IDLE;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  // interval selection for the state being entered
  always_comb begin
    tmr_load = (state_nxt != state_q);
    unique case (state_nxt)
      ST_SETUP:   tmr_val = SU_VAL;
      ST_WR_LOW:  tmr_val = WR_VAL;
      ST_WR_HOLD: tmr_val = HOLD_VAL;
      ST_LD_LOW:  tmr_val = LD_VAL;
      ST_LD_REC:  tmr_val = REC_VAL;
      default:    tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_q <= 1'b0;
    else if (accept) upd_q <= req_update & ~req_load_only;
  end

  // A request seen while busy must not alter the captured command (R7)
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(upd_q));

  // The load phase is only entered from idle or from the write hold (R6)
  p_ld_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_LD_LOW && state_nxt == ST_LD_LOW) |->
      (state_q == ST_IDLE || (state_q == ST_WR_HOLD && upd_q)));

endmodule

// File: rtl/dac_wr_bus.sv
module dac_wr_bus
  import dac_wr_pkg::*;
#(
  parameter int unsigned CHAN_W = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned WR_CYC = 6,
  parameter int unsigned LD_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state_nxt,
  input  logic              cap_en,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [DATA_W-1:0] req_code,
  output logic [CHAN_W-1:0] dac_addr,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_wr_n,
  output logic              dac_ld_n,
  output logic              ready,
  output logic              done
);

  // registered strobes and status, decoded from the state being entered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_wr_n <= 1'b1;
      dac_ld_n <= 1'b1;
      ready    <= 1'b1;
      done     <= 1'b0;
    end else begin
      dac_wr_n <= (state_nxt != ST_WR_LOW);
      dac_ld_n <= (state_nxt != ST_LD_LOW);
      ready    <= (state_nxt == ST_IDLE);
      done     <= (state_nxt == ST_DONE);
    end
  end

  // bus holding registers, loaded only when a write is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_addr <= '0;
      dac_data <= '0;
    end else if (cap_en) begin
      dac_addr <= req_chan;
      dac_data <= req_code;
    end
  end

  // pulse width monitors for the strobe assertions
  logic [CNT_W-1:0] wr_low_cnt;
  logic [CNT_W-1:0] ld_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_cnt <= '0;
      ld_low_cnt <= '0;
    end else begin
      if (!dac_wr_n) wr_low_cnt <= (wr_low_cnt == '1) ? wr_low_cnt : wr_low_cnt + 1'b1;
      else           wr_low_cnt <= '0;
      if (!dac_ld_n) ld_low_cnt <= (ld_low_cnt == '1) ? ld_low_cnt : ld_low_cnt + 1'b1;
      else           ld_low_cnt <= '0;
    end
  end

  p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> (wr_low_cnt == CNT_W'(WR_CYC)));

  p_ld_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_ld_n) |-> (ld_low_cnt == CNT_W'(LD_CYC)));

  p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_low_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |=> ($stable(dac_addr) && $stable(dac_data)));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dac_wr_n && !dac_ld_n));

  p_ld_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ld_n) |-> $past(dac_wr_n));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ready));

  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ready);

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int unsigned CHAN_W         = 2,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned CLK_NS         = 20,
  parameter int unsigned WR_LOW_NS      = 120,
  parameter int unsigned ADDR_SETUP_NS  = 0,
  parameter int unsigned ADDR_HOLD_NS   = 0,
  parameter int unsigned DATA_SETUP_NS  = 90,
  parameter int unsigned DATA_HOLD_NS   = 10,
  parameter int unsigned LD_LOW_NS      = 120,
  parameter int unsigned STROBE_GAP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_load_only,
  input  logic              req_update,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [DATA_W-1:0] req_code,
  output logic              ready,
  output logic              done,
  output logic [CHAN_W-1:0] dac_addr,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_wr_n,
  output logic              dac_ld_n
);

  localparam int unsigned WR_CYC   = max2(1, ceil_div(WR_LOW_NS, CLK_NS));
  localparam int unsigned LD_CYC   = max2(1, ceil_div(LD_LOW_NS, CLK_NS));
  localparam int unsigned AS_CYC   = ceil_div(ADDR_SETUP_NS, CLK_NS);
  localparam int unsigned DS_CYC   = ceil_div(DATA_SETUP_NS, CLK_NS);
  localparam int unsigned DS_REM   = (DS_CYC > WR_CYC) ? (DS_CYC - WR_CYC) : 0;
  localparam int unsigned SU_CYC   = max2(1, max2(AS_CYC, DS_REM));
  localparam int unsigned HOLD_CYC = max2(max2(1, STROBE_GAP_CYC),
                                          max2(ceil_div(DATA_HOLD_NS, CLK_NS),
                                               ceil_div(ADDR_HOLD_NS, CLK_NS)));
  localparam int unsigned REC_CYC  = max2(1, STROBE_GAP_CYC);
  localparam int unsigned MAX_CYC  = max2(max2(WR_CYC, LD_CYC),
                                          max2(max2(SU_CYC, HOLD_CYC), REC_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  seq_state_t       state_nxt;
  logic             accept;
  logic             tmr_load;
  logic             tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             cap_en;

  assign cap_en = accept & ~req_load_only;

  dac_wr_fsm #(
    .CNT_W    (CNT_W),
    .SU_CYC   (SU_CYC),
    .WR_CYC   (WR_CYC),
    .HOLD_CYC (HOLD_CYC),
    .LD_CYC   (LD_CYC),
    .REC_CYC  (REC_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_load_only (req_load_only),
    .req_update    (req_update),
    .tmr_expired   (tmr_expired),
    .state_nxt     (state_nxt),
    .accept        (accept),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val)
  );

  dac_wr_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dac_wr_bus #(
    .CHAN_W (CHAN_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .WR_CYC (WR_CYC),
    .LD_CYC (LD_CYC)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_nxt (state_nxt),
    .cap_en    (cap_en),
    .req_chan  (req_chan),
    .req_code  (req_code),
    .dac_addr  (dac_addr),
    .dac_data  (dac_data),
    .dac_wr_n  (dac_wr_n),
    .dac_ld_n  (dac_ld_n),
    .ready     (ready),
    .done      (done)
  );

endmodule

// File: tb/dac_wr_seq_tb.sv
module dac_wr_seq_tb;

  localparam int CLK_NS   = 20;
  localparam int WR_EXP   = (120 + CLK_NS - 1) / CLK_NS;
  localparam int LD_EXP   = (120 + CLK_NS - 1) / CLK_NS;
  localparam int SU_EXP   = 1;
  localparam int HOLD_EXP = 1;
  localparam int REC_EXP  = 1;
  localparam int LAT_WR   = SU_EXP + WR_EXP + HOLD_EXP;
  localparam int LAT_UPD  = LAT_WR + LD_EXP + REC_EXP;
  localparam int LAT_LD   = LD_EXP + REC_EXP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_load_only = 1'b0;
  logic       req_update = 1'b0;
  logic [1:0] req_chan = 2'd0;
  logic [7:0] req_code = 8'd0;
  logic       ready, done, dac_wr_n, dac_ld_n;
  logic [1:0] dac_addr;
  logic [7:0] dac_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  dac_wr_seq u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
    .req_load_only (req_load_only), .req_update (req_update),
    .req_chan (req_chan), .req_code (req_code), .ready (ready), .done (done),
    .dac_addr (dac_addr), .dac_data (dac_data),
    .dac_wr_n (dac_wr_n), .dac_ld_n (dac_ld_n)
  );

  // bus monitor, sampling at falling clock edges
  logic       p_wr = 1'b1, p_ld = 1'b1;
  logic [1:0] p_addr = '0;
  logic [7:0] p_data = '0;
  int wr_run = 0, ld_run = 0, wr_width = 0, ld_width = 0;
  int wr_pulses = 0, ld_pulses = 0, stab_bad = 0, overlap = 0, gap_bad = 0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dac_wr_n) begin
        wr_run = p_wr ? 1 : wr_run + 1;
        if (dac_addr != p_addr || dac_data != p_data) stab_bad++;
      end else if (!p_wr) begin
        wr_width = wr_run; wr_pulses++;
        wr_addr = dac_addr; wr_data = dac_data;
        if (dac_addr != p_addr || dac_data != p_data) stab_bad++;
      end
      if (!dac_ld_n) ld_run = p_ld ? 1 : ld_run + 1;
      else if (!p_ld) begin ld_width = ld_run; ld_pulses++; end
      if (!dac_wr_n && !dac_ld_n) overlap++;
      if (!dac_ld_n && p_ld && (!p_wr || !dac_wr_n)) gap_bad++;
      p_wr = dac_wr_n; p_ld = dac_ld_n; p_addr = dac_addr; p_data = dac_data;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue one request, return edge count to done, ready faults, done width
  task automatic do_req(input bit lo, input bit upd, input logic [1:0] ch,
                        input logic [7:0] code, input int inj_at,
                        output int lat, output int rdy_bad, output int done_w);
    @(negedge clk);
    req_valid = 1'b1; req_load_only = lo; req_update = upd;
    req_chan = ch; req_code = code;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; rdy_bad = 0;
    while (!done && lat < 100) begin
      if (ready) rdy_bad++;
      if (lat == inj_at) begin
        req_valid = 1'b1; req_load_only = 1'b0; req_update = 1'b1;
        req_chan = ~ch; req_code = ~code;
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (ready) rdy_bad++;
    @(posedge clk);
    @(negedge clk);
    done_w = done ? 2 : 1;
    if (!ready) rdy_bad++;
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 wr_n in reset", dac_wr_n, 1);
    chk("R1 ld_n in reset", dac_ld_n, 1);
    chk("R1 ready in reset", ready, 1);
    chk("R1 done in reset", done, 0);
    chk("R1 addr/data in reset", {dac_addr, dac_data}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {dac_wr_n, dac_ld_n, ready, done}, 4'b1110);
  endtask

  task automatic t_write(input logic [1:0] ch, input logic [7:0] code);
    int lat, rb, dw, w0, l0, s0;
    w0 = wr_pulses; l0 = ld_pulses; s0 = stab_bad;
    do_req(1'b0, 1'b0, ch, code, -1, lat, rb, dw);
    chk("R2 addr at wr rise", wr_addr, ch);
    chk("R2 data at wr rise", wr_data, code);
    chk("R3 wr_n low width", wr_width, WR_EXP);
    chk("R4 bus stability", stab_bad - s0, 0);
    chk("R6 one write pulse", wr_pulses - w0, 1);
    chk("R6 no load without update", ld_pulses - l0, 0);
    chk("R7 ready low while busy", rb, 0);
    chk("R8 done width", dw, 1);
    chk("R11 write latency", lat, LAT_WR);
  endtask

  task automatic t_write_upd(input logic [1:0] ch, input logic [7:0] code);
    int lat, rb, dw, w0, l0, o0, g0;
    w0 = wr_pulses; l0 = ld_pulses; o0 = overlap; g0 = gap_bad;
    do_req(1'b0, 1'b1, ch, code, -1, lat, rb, dw);
    chk("R2 addr with update", wr_addr, ch);
    chk("R2 data with update", wr_data, code);
    chk("R6 one write pulse", wr_pulses - w0, 1);
    chk("R6 one load pulse", ld_pulses - l0, 1);
    chk("R5 ld_n low width", ld_width, LD_EXP);
    chk("R5 no strobe overlap", overlap - o0, 0);
    chk("R5 load after write high", gap_bad - g0, 0);
    chk("R7 ready low while busy", rb, 0);
    chk("R8 done width", dw, 1);
    chk("R11 write+load latency", lat, LAT_UPD);
  endtask

  task automatic t_load_only();
    int lat, rb, dw, w0, l0;
    logic [9:0] bus0;
    w0 = wr_pulses; l0 = ld_pulses;
    bus0 = {dac_addr, dac_data};
    do_req(1'b1, 1'b0, ~dac_addr, ~dac_data, -1, lat, rb, dw);
    chk("R9 no write pulse", wr_pulses - w0, 0);
    chk("R9 one load pulse", ld_pulses - l0, 1);
    chk("R9 bus unchanged", {dac_addr, dac_data}, bus0);
    chk("R5 ld_n width load-only", ld_width, LD_EXP);
    chk("R8 done width load-only", dw, 1);
    chk("R11 load-only latency", lat, LAT_LD);
  endtask

  task automatic t_busy_ignore();
    int lat, rb, dw, w0, l0;
    w0 = wr_pulses; l0 = ld_pulses;
    do_req(1'b0, 1'b0, 2'd2, 8'h5A, 3, lat, rb, dw);
    chk("R7 busy request ignored: writes", wr_pulses - w0, 1);
    chk("R7 busy request ignored: loads", ld_pulses - l0, 0);
    chk("R7 busy request ignored: bus", {dac_addr, dac_data}, {2'd2, 8'h5A});
    chk("R7 busy latency unchanged", lat, LAT_WR);
    repeat (3) @(negedge clk);
    chk("R7 nothing started after", {wr_pulses - w0, ld_pulses - l0, 1'b0 + ready}, {32'd1, 32'd0, 1'b1});
  endtask

  task automatic t_hold_idle();
    logic [9:0] bus0;
    bus0 = {dac_addr, dac_data};
    repeat (10) @(negedge clk);
    chk("R10 bus held idle", {dac_addr, dac_data}, bus0);
    chk("R10 strobes high idle", {dac_wr_n, dac_ld_n}, 2'b11);
  endtask

  initial begin
    t_reset();
    t_write(2'd0, 8'h00);
    t_write(2'd1, 8'hA5);
    t_write(2'd3, 8'hFF);
    t_write_upd(2'd2, 8'h3C);
    t_hold_idle();
    t_load_only();
    t_busy_ignore();
    t_write_upd(2'd0, 8'h81);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule